// File: doc/BRIEF.md
# Decimated Preamble Carrier-Offset Estimator

This block measures the carrier frequency offset of an OFDM preamble while running at one quarter of the sample rate. On every clock the receive path delivers four parallel complex samples. A lane selector keeps one of them, so the decimated stream runs at the clock rate. After a start strobe, the kept samples are written into an addressed register file. Writing stops once two windows of 41 samples, 82 entries in all, have been stored.

The block then forms two delayed-correlation sums from the stored data. Each sum multiplies a sample by the conjugate of the sample 41 entries later. The coarse sum covers pairs 0 to 19 and the fine sum covers pairs 20 to 40. Each sum is converted to a phase angle by an iterative vectoring CORDIC.

When the two angles agree within a programmable threshold, the output is their wrap-aware mean. When they disagree, the fine angle is treated as hit by a burst and only the coarse angle is reported. The result appears together with a single-cycle done pulse.

Top module: `cfo_est_decim`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `est` is 0 until the first estimate completes.
- R2: Lane k of `in_lanes` occupies bits [8k+7:8k], with I (signed 4-bit) in the upper nibble and Q (signed 4-bit) in the lower nibble. Only the lane picked by `keep_lane` is stored, and the content of the other three lanes has no effect on `est`.
- R3: A sample is stored only in a cycle where `in_valid` is high after `start` has been taken. No estimate completes before 82 such samples have been accepted, and cycles with `in_valid` low are skipped.
- R4: With stored samples r[0..81], the coarse angle is arg of the sum over n=0..19 of r[n]·conj(r[n+41]), and the fine angle is the same over n=20..40. Angles are signed 12-bit values in units of pi/2048 and come within 8 units of the exact value, modulo 4096.
- R5: With d the wrapped difference fine minus coarse, the result is coarse + d/2 when |d| <= `agree_thr`, and coarse otherwise.
- R6: `done` is high for exactly one cycle per estimate, and `est` changes only in the cycle in which `done` is high.
- R7: A `start` pulse while an estimate is in progress is ignored and does not restart sample collection.
- R8: The correlation sums cannot overflow, even when every sample is full scale (-8,-8). Such input yields an angle of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at one quarter of the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new collection when idle |
| in_valid | input | 1 | Qualifies the four lanes in this cycle |
| in_lanes | input | 32 | Four complex samples, 8 bits each |
| keep_lane | input | 2 | Index of the lane that is kept |
| agree_thr | input | 12 | Largest coarse/fine difference, in pi/2048 units, that still counts as agreement |
| est | output | 12 | Signed phase estimate, pi/2048 units |
| done | output | 1 | One-cycle pulse when `est` is updated |

## Verification
The checks assume that `keep_lane` and `agree_thr` stay constant during an estimate. They also assume that `start` and `in_valid` are known values once reset is released. The bench changes lane and threshold only between estimates, and drives every input from reset onward.

The exact-value checks assume the chosen threshold does not lie within the CORDIC error of the true coarse/fine difference. The stimulus therefore uses either clean tones, where the two angles differ by a few units, or a polarity-flipped burst, where they differ by about pi.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
  localparam int SW     = 4;
  localparam int LANES  = 4;
  localparam int WIN    = 41;
  localparam int HALF   = WIN / 2;
  localparam int DEPTH  = 2 * WIN;
  localparam int AW     = $clog2(DEPTH + 1);
  localparam int LW     = $clog2(LANES);
  localparam int PW     = 12;
  localparam int ITER   = 12;
  localparam int IW     = $clog2(ITER);
  localparam int RW     = $clog2(ITER + 1);
  localparam int PRODW  = 2 * SW + 1;
  localparam int ACCW   = PRODW + $clog2(WIN);
  localparam int CW     = ACCW + 2;

  typedef struct packed {
    logic signed [SW-1:0] i;
    logic signed [SW-1:0] q;
  } cplx_t;

  // arctan(2^-k) in units of pi/2^(PW-1)
  function automatic logic signed [PW-1:0] atan_step(input logic [IW-1:0] k);
    case (k)
      4'd0:    atan_step = 12'sd512;
      4'd1:    atan_step = 12'sd302;
      4'd2:    atan_step = 12'sd160;
      4'd3:    atan_step = 12'sd81;
      4'd4:    atan_step = 12'sd41;
      4'd5:    atan_step = 12'sd20;
      4'd6:    atan_step = 12'sd10;
      4'd7:    atan_step = 12'sd5;
      4'd8:    atan_step = 12'sd3;
      4'd9:    atan_step = 12'sd1;
      4'd10:   atan_step = 12'sd1;
      default: atan_step = 12'sd0;
    endcase
  endfunction
endpackage

// File: rtl/lane_pick.sv
module lane_pick
  import cfo_pkg::*;
(
  input  logic [LANES*2*SW-1:0] lanes,
  input  logic [LW-1:0]         pick,
  output cplx_t                 sample
);
  cplx_t lane_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign lane_arr[g] = lanes[g*2*SW +: 2*SW];
  end

  assign sample = lane_arr[pick];
endmodule

// File: rtl/sample_rf.sv
module sample_rf
  import cfo_pkg::*;
(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  cplx_t         wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output cplx_t         rdata_a,
  output cplx_t         rdata_b
);
  cplx_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata_a = (raddr_a < AW'(DEPTH)) ? mem[raddr_a] : '0;
    rdata_b = (raddr_b < AW'(DEPTH)) ? mem[raddr_b] : '0;
  end

  // R3: writes stay inside the two stored windows
  always @(posedge clk) begin
    if (we) p_waddr_in_range_r3: assert (waddr < AW'(DEPTH));
  end
endmodule

// File: rtl/corr_acc.sv
module corr_acc
  import cfo_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  cplx_t                  a,
  input  cplx_t                  b,
  output logic signed [ACCW-1:0] acc_re,
  output logic signed [ACCW-1:0] acc_im
);
  localparam int BOUND = (1 << (2*SW - 1)) * WIN;

  logic signed [PRODW-1:0] prod_re, prod_im;
  logic signed [ACCW-1:0]  re_n, im_n;

  always_comb begin
    prod_re = PRODW'(a.i * b.i) + PRODW'(a.q * b.q);
    prod_im = PRODW'(a.q * b.i) - PRODW'(a.i * b.q);
    re_n = acc_re;
    im_n = acc_im;
    if (clr) begin
      re_n = '0;
      im_n = '0;
    end else if (en) begin
      re_n = acc_re + ACCW'(prod_re);
      im_n = acc_im + ACCW'(prod_im);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
    end else begin
      acc_re <= re_n;
      acc_im <= im_n;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re <= ACCW'(BOUND)) && (acc_re >= -ACCW'(BOUND)) &&
    (acc_im <= ACCW'(BOUND)) && (acc_im >= -ACCW'(BOUND)));
endmodule

// File: rtl/cordic_vec.sv
module cordic_vec
  import cfo_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   step,
  input  logic [IW-1:0]          idx,
  input  logic signed [ACCW-1:0] xin,
  input  logic signed [ACCW-1:0] yin,
  output logic signed [PW-1:0]   angle
);
  logic signed [CW-1:0] x_q, y_q, x_n, y_n, xs, ys;
  logic signed [PW-1:0] z_q, z_n;

  always_comb begin
    x_n = x_q;
    y_n = y_q;
    z_n = z_q;
    xs  = x_q >>> idx;
    ys  = y_q >>> idx;
    if (load) begin
      if (xin < 0) begin
        x_n = -CW'(xin);
        y_n = -CW'(yin);
        z_n = {1'b1, {(PW-1){1'b0}}};
      end else begin
        x_n = CW'(xin);
        y_n = CW'(yin);
        z_n = '0;
      end
    end else if (step) begin
      if (y_q >= 0) begin
        x_n = x_q + ys;
        y_n = y_q - xs;
        z_n = z_q + atan_step(idx);
      end else begin
        x_n = x_q - ys;
        y_n = y_q + xs;
        z_n = z_q - atan_step(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
    end
  end

  assign angle = z_q;

  // R4: vectoring keeps the working vector in the right half-plane
  p_x_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (x_q >= 0));
endmodule

// File: rtl/cfo_est_decim.sv
module cfo_est_decim
  import cfo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 in_valid,
  input  logic [LANES*2*SW-1:0] in_lanes,
  input  logic [LW-1:0]        keep_lane,
  input  logic [PW-1:0]        agree_thr,
  output logic signed [PW-1:0] est,
  output logic                 done
);
  typedef enum logic [2:0] {S_IDLE, S_FILL, S_ACC, S_ROT, S_DONE} st_t;

  st_t                  state, state_n;
  logic [AW-1:0]        wptr, wptr_n, cnt, cnt_n;
  logic [RW-1:0]        rot_cnt, rot_n;
  logic                 pass, pass_n;
  logic signed [PW-1:0] coarse_q, coarse_n, est_q, est_n, fine_ang;
  logic                 done_q, done_n;

  cplx_t                  kept, ra, rb;
  logic signed [ACCW-1:0] acc_re, acc_im;
  logic signed [PW-1:0]   diff, merged;
  logic        [PW:0]     mag;

  lane_pick u_pick (.lanes(in_lanes), .pick(keep_lane), .sample(kept));

  sample_rf u_rf (
    .clk(clk), .we(state == S_FILL && in_valid), .waddr(wptr), .wdata(kept),
    .raddr_a(cnt), .raddr_b(cnt + AW'(WIN)), .rdata_a(ra), .rdata_b(rb)
  );

  corr_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clr(state != S_ACC), .en(state == S_ACC),
    .a(ra), .b(rb), .acc_re(acc_re), .acc_im(acc_im)
  );

  cordic_vec u_cordic (
    .clk(clk), .rst_n(rst_n),
    .load(state == S_ROT && rot_cnt == '0),
    .step(state == S_ROT && rot_cnt != '0),
    .idx(IW'(rot_cnt - 1'b1)),
    .xin(acc_re), .yin(acc_im), .angle(fine_ang)
  );

  always_comb begin
    diff   = fine_ang - coarse_q;
    mag    = diff[PW-1] ? -{diff[PW-1], diff} : {1'b0, diff};
    merged = (mag <= {1'b0, agree_thr}) ? coarse_q + (diff >>> 1) : coarse_q;
  end

  always_comb begin
    state_n  = state;
    wptr_n   = wptr;
    cnt_n    = cnt;
    rot_n    = rot_cnt;
    pass_n   = pass;
    coarse_n = coarse_q;
    est_n    = est_q;
    done_n   = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        state_n = S_FILL;
        wptr_n  = '0;
      end
      S_FILL: if (in_valid) begin
        wptr_n = wptr + 1'b1;
        if (wptr == AW'(DEPTH - 1)) begin
          state_n = S_ACC;
          cnt_n   = '0;
          pass_n  = 1'b0;
        end
      end
      S_ACC: begin
        cnt_n = cnt + 1'b1;
        if (pass && cnt == AW'(HALF)) coarse_n = fine_ang;
        if (cnt == (pass ? AW'(WIN - 1) : AW'(HALF - 1))) begin
          state_n = S_ROT;
          rot_n   = '0;
        end
      end
      S_ROT: begin
        rot_n = rot_cnt + 1'b1;
        if (rot_cnt == RW'(ITER)) begin
          if (!pass) begin
            state_n = S_ACC;
            pass_n  = 1'b1;
            cnt_n   = AW'(HALF);
          end else begin
            state_n = S_DONE;
          end
        end
      end
      S_DONE: begin
        est_n   = merged;
        done_n  = 1'b1;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wptr     <= '0;
      cnt      <= '0;
      rot_cnt  <= '0;
      pass     <= 1'b0;
      coarse_q <= '0;
      est_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state    <= state_n;
      wptr     <= wptr_n;
      cnt      <= cnt_n;
      rot_cnt  <= rot_n;
      pass     <= pass_n;
      coarse_q <= coarse_n;
      est_q    <= est_n;
      done_q   <= done_n;
    end
  end

  assign est  = est_q;
  assign done = done_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_est_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(est) |-> done);
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && wptr != '0 && start) |=> (wptr != '0));
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL) |-> (wptr < AW'(DEPTH)));
endmodule

// File: tb/cfo_est_decim_test.sv
module cfo_est_decim_test;
  localparam int NV = 6;
  localparam int TOL = 8;
  // columns: phase step per sample (pi/1024 units), burst flip, threshold, lane
  localparam int VEC [NV][4] = '{
    '{10, 0, 200, 0},
    '{25, 0, 200, 1},
    '{-7, 0, 200, 2},
    '{10, 1, 200, 3},
    '{3, 1, 100, 0},
    '{-15, 0, 2047, 2}
  };

  logic clk = 1'b0;
  logic rst_n, start, in_valid;
  logic [31:0] in_lanes;
  logic [1:0] keep_lane;
  logic [11:0] agree_thr;
  logic signed [11:0] est;
  logic done;

  int n_chk = 0, n_fail = 0, cyc = 0, seed = 17;
  int si [82];
  int sq [82];

  cfo_est_decim uut (.clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_lanes(in_lanes), .keep_lane(keep_lane), .agree_thr(agree_thr),
    .est(est), .done(done));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic int wrapd(int v);
    int m = ((v % 4096) + 4096) % 4096;
    return (m >= 2048) ? m - 4096 : m;
  endfunction

  function automatic int rnd(real x);
    return $rtoi(x >= 0.0 ? x + 0.5 : x - 0.5);
  endfunction

  task automatic check(string req, int act, int exp, int tol);
    n_chk++;
    if (wrapd(act - exp) > tol || wrapd(act - exp) < -tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic real ang(int lo, int hi);
    int re = 0, im = 0;
    for (int n = lo; n <= hi; n++) begin
      re += si[n] * si[n+41] + sq[n] * sq[n+41];
      im += sq[n] * si[n+41] - si[n] * sq[n+41];
    end
    return $atan2(real'(im), real'(re)) * 2048.0 / 3.14159265358979;
  endfunction

  function automatic logic [31:0] pack(int lane, int k);
    logic [31:0] w;
    for (int l = 0; l < 4; l++) begin
      seed = seed * 1103515245 + 12345;
      w[l*8 +: 8] = (l == lane) ? {4'(si[k]), 4'(sq[k])} : 8'(seed >>> 16);
    end
    return w;
  endfunction

  // feed 'cnt' valid samples from index 'from'; every 5th cycle invalid junk
  task automatic feed(int lane, int from, int cnt, bit mid_start);
    int k = from, t = 0;
    while (k < from + cnt) begin
      @(negedge clk);
      in_valid = (t % 5 != 4);
      in_lanes = pack(lane, k);
      if (!in_valid) in_lanes = ~in_lanes;
      start = mid_start && (k == from + 30);
      if (in_valid) k++;
      t++;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; start = 1'b0; in_lanes = '1;
  endtask

  task automatic begin_est(int lane, int thr);
    @(negedge clk);
    keep_lane = 2'(lane); agree_thr = 12'(thr); start = 1'b1;
    in_valid = 1'b1; in_lanes = '1;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic wait_done(string req, output int got);
    int t = 0;
    got = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    n_chk++;
    if (!done) begin
      n_fail++;
      $display("FAIL %s done: actual 0 expected 1", req);
    end else begin
      got = int'(est);
      @(negedge clk);
      check("R6 pulse width", int'(done), 0, 0);
    end
  endtask

  task automatic make_tone(int w, int burst);
    for (int k = 0; k < 82; k++) begin
      real ph = 0.3 + real'(w) * 3.14159265358979 / 1024.0 * real'(k);
      si[k] = rnd(7.0 * $cos(ph));
      sq[k] = rnd(7.0 * $sin(ph));
      if (burst != 0 && k >= 61) begin si[k] = -si[k]; sq[k] = -sq[k]; end
    end
  endtask

  function automatic int expect_est(int thr);
    real c = ang(0, 19), f = ang(20, 40);
    int ci = rnd(c), d = wrapd(rnd(f) - ci);
    if ((d < 0 ? -d : d) <= thr) return wrapd(rnd(c + real'(d) / 2.0));
    return wrapd(ci);
  endfunction

  initial begin
    int got, got2, hold;
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_lanes = '0;
    keep_lane = '0; agree_thr = '0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done), 0, 0);
    check("R1 est in reset", int'(est), 0, 0);
    rst_n = 1'b1;
    // samples presented before any start must be ignored (R3)
    make_tone(40, 0);
    repeat (4) begin @(negedge clk); in_valid = 1'b1; in_lanes = pack(0, 0); end
    @(negedge clk); in_valid = 1'b0;
    check("R1 done after reset", int'(done), 0, 0);

    // table walk: R4 angle, R5 merge rule, R2 lane choice
    for (int v = 0; v < NV; v++) begin
      make_tone(VEC[v][0], VEC[v][1]);
      begin_est(VEC[v][3], VEC[v][2]);
      feed(VEC[v][3], 0, 82, 1'b0);
      wait_done("R4", got);
      check((VEC[v][1] != 0) ? "R5 burst keeps coarse" : "R4 R5 merged estimate",
            got, expect_est(VEC[v][2]), TOL);
    end

    // R2: same data in another lane, other lanes different junk -> same result
    make_tone(-20, 0);
    begin_est(1, 300); feed(1, 0, 82, 1'b0); wait_done("R2", got);
    begin_est(3, 300); feed(3, 0, 82, 1'b0); wait_done("R2", got2);
    check("R2 lane independence", got2, got, 0);

    // R3: 81 samples give no result; the 82nd completes it
    make_tone(12, 0);
    begin_est(0, 300);
    feed(0, 0, 81, 1'b0);
    hold = 0;
    repeat (100) begin @(negedge clk); if (done) hold = 1; end
    check("R3 no done before 82 samples", hold, 0, 0);
    feed(0, 81, 1, 1'b0);
    wait_done("R3", got);
    check("R3 estimate after last sample", got, expect_est(300), TOL);

    // R6: est held while idle after done
    hold = 0;
    repeat (20) begin @(negedge clk); if (int'(est) != got) hold = 1; end
    check("R6 est held", hold, 0, 0);

    // R7: start in the middle of collection is ignored
    make_tone(-5, 0);
    begin_est(2, 300);
    feed(2, 0, 82, 1'b1);
    wait_done("R7", got);
    check("R7 mid start ignored", got, expect_est(300), TOL);

    // R8: full-scale input everywhere -> angle 0, no overflow
    for (int k = 0; k < 82; k++) begin si[k] = -8; sq[k] = -8; end
    begin_est(0, 300); feed(0, 0, 82, 1'b0);
    wait_done("R8", got);
    check("R8 full scale angle", got, 0, TOL);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule